// File: doc/BRIEF.md
# Block-Lock Write-Protect Controller

This block is the policy stage that sits between a serial-memory command decoder and the nonvolatile array. For every requested write it decides whether the write may proceed, and it holds the protection register that steers that decision. The protection register lives at the all-ones address of the request address space. It contains a volatile write-enable latch bit, a two-bit block-select field that protects nothing, the top quarter, the top half or the whole array, and a hardware-lock enable bit. When the hardware-lock enable bit and the external write-protect pin are both high, the register refuses every change to its block-select and lock fields.

The protocol engine presents one request per cycle with `wr_req`, `wr_addr`, `wr_data` and the level of the write-protect pin. One cycle later the block answers with exactly one of `grant` or `refuse`. The array is written only on `grant`. A refused write leaves all state unchanged, so the serial transaction can still finish normally while the refusal is reported. The register fields are output at all times, together with the current lock condition.

Top module: `wp_guard`

## Requirements
- R1: After reset, `latch_o`, `blk_o` and `hw_en_o` are 0, and `grant`, `refuse` and `locked_o` are 0.
- R2: An array write (address below `ARRAY_BYTES`) made while the latch bit is 0 is refused.
- R3: The block-select field sets the protected array region: 2'b00 protects none, 2'b01 protects [3N/4, N), 2'b10 protects [N/2, N) and 2'b11 protects [0, N), where N = `ARRAY_BYTES`. An array write inside that region is refused.
- R4: An array write outside the protected region, made while the latch bit is 1, is granted.
- R5: A request to the all-ones address is a register write. It always loads the latch bit from `wr_data[0]`, whether or not the rest of the write is refused.
- R6: A register write loads the block-select field from `wr_data[3:2]` and the hardware-lock enable bit from `wr_data[7]`, and is granted, only if the latch bit was already 1 before the write and the register is not locked. Otherwise it is refused and those fields keep their values.
- R7: While `wp_pin` and the hardware-lock enable bit are both 1, `locked_o` is 1 and every register write is refused with block-select and hardware-lock enable unchanged.
- R8: While `wp_pin` is 0, a set hardware-lock enable bit does not lock the register. A register write made with the latch bit set can change block-select and can clear the hardware-lock enable bit.
- R9: A write to an address at or above `ARRAY_BYTES` other than the all-ones address is refused.
- R10: Each request produces exactly one of `grant` or `refuse` in the following cycle. No response appears in a cycle that follows a cycle with no request.
- R11: Block-select and hardware-lock enable change only in the cycle after a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request valid this cycle |
| wr_addr | input | ADDR_W | Target address of the write |
| wr_data | input | DATA_W | Data byte of the write |
| wp_pin | input | 1 | External write-protect pin level |
| grant | output | 1 | Write allowed (one cycle after request) |
| refuse | output | 1 | Write rejected (one cycle after request) |
| latch_o | output | 1 | Write-enable latch bit |
| blk_o | output | 2 | Block-select field |
| hw_en_o | output | 1 | Hardware-lock enable bit |
| locked_o | output | 1 | Register currently locked (pin and enable both high) |

## Verification
Several properties are checked on every cycle:
- the one-hot, one-cycle response;
- refusal whenever the latch bit is clear, the whole array is protected, the address falls in the unmapped gap, or the register is locked;
- the latch bit following the written data;
- the protection fields holding except after register writes.

The exact region boundaries for the quarter and half settings, the grant of writes just below each boundary, and the way the pin and enable bit lock the register and later release it can only be shown by the bench. It drives directed boundary sequences, followed by constrained random traffic compared against a reference model.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

   // Block-select encoding: which upper part of the array is protected
   typedef enum logic [1:0] {
      BLK_NONE    = 2'b00,
      BLK_QUARTER = 2'b01,
      BLK_HALF    = 2'b10,
      BLK_ALL     = 2'b11
   } blk_sel_e;

   // Class of a request address
   typedef enum logic [1:0] {
      TGT_ARRAY = 2'b00,
      TGT_PREG  = 2'b01,
      TGT_VOID  = 2'b10
   } target_e;

   // Field positions inside a protection-register write byte
   localparam int FLD_LATCH  = 0;
   localparam int FLD_BLK_LO = 2;
   localparam int FLD_HWEN   = 7;

   typedef struct packed {
      logic     hw_en;
      blk_sel_e blk;
      logic     latch;
   } prot_state_t;

endpackage

// File: rtl/wp_region_map.sv
module wp_region_map
   import wp_guard_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int ARRAY_BYTES = 4096
) (
   input  logic [ADDR_W-1:0] addr,
   input  blk_sel_e          blk,
   output target_e           target,
   output logic              in_zone
);

   localparam int EXT_W = ADDR_W + 1;
   localparam logic [EXT_W-1:0] SPAN = EXT_W'(ARRAY_BYTES);

   logic [EXT_W-1:0] floor_tab [4];
   logic [EXT_W-1:0] addr_ext;

   assign addr_ext = {1'b0, addr};

   // Lowest protected address for each block-select code
   generate
      for (genvar k = 0; k < 4; k++) begin : g_floor
         localparam int FLOOR = (k == 0) ? ARRAY_BYTES :
                                (k == 1) ? ARRAY_BYTES - ARRAY_BYTES / 4 :
                                (k == 2) ? ARRAY_BYTES / 2 : 0;
         assign floor_tab[k] = EXT_W'(FLOOR);
      end
   endgenerate

   always_comb begin
      if (addr == '1)
         target = TGT_PREG;
      else if (addr_ext < SPAN)
         target = TGT_ARRAY;
      else
         target = TGT_VOID;
   end

   assign in_zone = (target == TGT_ARRAY) && (addr_ext >= floor_tab[blk]);

endmodule

// File: rtl/wp_prot_reg.sv
module wp_prot_reg
   import wp_guard_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              fields_ok,
   input  logic [DATA_W-1:0] wr_data,
   output prot_state_t       state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= '{hw_en: 1'b0, blk: BLK_NONE, latch: 1'b0};
      end else if (wr_en) begin
         state.latch <= wr_data[FLD_LATCH];
         if (fields_ok) begin
            state.blk   <= blk_sel_e'(wr_data[FLD_BLK_LO+1:FLD_BLK_LO]);
            state.hw_en <= wr_data[FLD_HWEN];
         end
      end
   end

   logic unused_data_bits;
   assign unused_data_bits = ^wr_data;

endmodule

// File: rtl/wp_verdict.sv
module wp_verdict (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic allow,
   output logic grant,
   output logic refuse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant  <= 1'b0;
         refuse <= 1'b0;
      end else begin
         grant  <= req & allow;
         refuse <= req & ~allow;
      end
   end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
   import wp_guard_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int ARRAY_BYTES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wp_pin,
   output logic              grant,
   output logic              refuse,
   output logic              latch_o,
   output logic [1:0]        blk_o,
   output logic              hw_en_o,
   output logic              locked_o
);

   // Elaboration-time parameter checks
   generate
      if (ARRAY_BYTES < 4 || (ARRAY_BYTES & (ARRAY_BYTES - 1)) != 0) begin : g_bad_span
         $error("wp_guard: ARRAY_BYTES must be a power of two of at least 4");
      end
      if (ADDR_W < 3 || ADDR_W > 30 || ARRAY_BYTES >= (1 << ADDR_W)) begin : g_bad_addr
         $error("wp_guard: array must fit below the all-ones register address");
      end
      if (DATA_W <= FLD_HWEN) begin : g_bad_data
         $error("wp_guard: DATA_W too narrow for register fields");
      end
   endgenerate

   prot_state_t st;
   target_e     target;
   logic        in_zone;
   logic        locked;
   logic        preg_ok;
   logic        allow;

   wp_region_map #(
      .ADDR_W     (ADDR_W),
      .ARRAY_BYTES(ARRAY_BYTES)
   ) map_i (
      .addr   (wr_addr),
      .blk    (st.blk),
      .target (target),
      .in_zone(in_zone)
   );

   assign locked  = wp_pin & st.hw_en;
   assign preg_ok = st.latch & ~locked;

   always_comb begin
      unique case (target)
         TGT_ARRAY: allow = st.latch & ~in_zone;
         TGT_PREG:  allow = preg_ok;
         default:   allow = 1'b0;
      endcase
   end

   wp_prot_reg #(
      .DATA_W(DATA_W)
   ) preg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_req && target == TGT_PREG),
      .fields_ok(preg_ok),
      .wr_data  (wr_data),
      .state    (st)
   );

   wp_verdict verdict_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (wr_req),
      .allow (allow),
      .grant (grant),
      .refuse(refuse)
   );

   assign latch_o  = st.latch;
   assign blk_o    = st.blk;
   assign hw_en_o  = st.hw_en;
   assign locked_o = locked;

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
   parameter int ADDR_W      = 16,
   parameter int ARRAY_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_latch_bit,
   input logic              wp_pin,
   input logic              grant,
   input logic              refuse,
   input logic              latch_o,
   input logic [1:0]        blk_o,
   input logic              hw_en_o
);

   localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(ARRAY_BYTES);

   logic is_array, is_preg;
   assign is_array = {1'b0, wr_addr} < SPAN;
   assign is_preg  = wr_addr == '1;

   p_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, refuse}));

   p_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> (grant || refuse));

   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> (!grant && !refuse));

   p_nolatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && is_array && !latch_o) |=> refuse);

   p_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && is_array && blk_o == 2'b11) |=> refuse);

   p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && is_preg) |=> (latch_o == $past(wr_latch_bit)));

   p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && is_preg && wp_pin && hw_en_o) |=>
         (refuse && $stable(blk_o) && $stable(hw_en_o)));

   p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !is_array && !is_preg) |=> refuse);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_req && is_preg) |=> ($stable(blk_o) && $stable(hw_en_o)));

endmodule

bind wp_guard wp_guard_chk #(
   .ADDR_W     (ADDR_W),
   .ARRAY_BYTES(ARRAY_BYTES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_req      (wr_req),
   .wr_addr     (wr_addr),
   .wr_latch_bit(wr_data[wp_guard_pkg::FLD_LATCH]),
   .wp_pin      (wp_pin),
   .grant       (grant),
   .refuse      (refuse),
   .latch_o     (latch_o),
   .blk_o       (blk_o),
   .hw_en_o     (hw_en_o)
);

// File: tb/wp_guard_tb_top.sv
module wp_guard_tb_top;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int N  = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_req = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wp_pin = 1'b0;
   logic          grant, refuse, latch_o, hw_en_o, locked_o;
   logic [1:0]    blk_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // model state
   logic       m_latch = 1'b0;
   logic [1:0] m_blk = 2'b00;
   logic       m_hwen = 1'b0;

   always #10 clk = ~clk;

   wp_guard #(.ADDR_W(AW), .DATA_W(DW), .ARRAY_BYTES(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .wp_pin(wp_pin), .grant(grant), .refuse(refuse),
      .latch_o(latch_o), .blk_o(blk_o), .hw_en_o(hw_en_o), .locked_o(locked_o)
   );

   function automatic int floor_of(input logic [1:0] b);
      case (b)
         2'b00:   return N;
         2'b01:   return N - N / 4;
         2'b10:   return N / 2;
         default: return 0;
      endcase
   endfunction

   function automatic logic [6:0] observed();
      return {grant, refuse, latch_o, blk_o, hw_en_o, locked_o};
   endfunction

   task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b (grant,refuse,latch,blk,hwen,locked)",
                  tag, act, exp);
      end
   endtask

   // One request; inputs driven at negedge, response checked at following negedge
   task automatic req(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic w, input string tag);
      logic ok;
      @(negedge clk);
      wr_req = 1'b1; wr_addr = a; wr_data = d; wp_pin = w;
      if (a == '1) begin
         ok = m_latch && !(w && m_hwen);
         if (ok) begin
            m_blk  = d[3:2];
            m_hwen = d[7];
         end
         m_latch = d[0];
      end else if (int'(a) < N) begin
         ok = m_latch && (int'(a) < floor_of(m_blk));
      end else begin
         ok = 1'b0;
      end
      @(negedge clk);
      wr_req = 1'b0;
      check(tag, observed(), {ok, !ok, m_latch, m_blk, m_hwen, w & m_hwen});
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      wr_req = 1'b0;
      @(negedge clk);
      check(tag, observed(), {2'b00, m_latch, m_blk, m_hwen, wp_pin & m_hwen});
   endtask

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int seed_v;
      seed_v = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      check("R1 in reset", observed(), 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", observed(), 7'b0);

      req(16'h0010, 8'h00, 1'b0, "R2 latch clear");
      req(16'hFFFF, 8'h0C, 1'b0, "R6 fields without latch");
      req(16'hFFFF, 8'h01, 1'b0, "R5 set latch");
      req(16'h0FFF, 8'h00, 1'b0, "R4 none protected");
      req(16'hFFFF, 8'h05, 1'b0, "R6 select quarter");
      req(16'h0C00, 8'h00, 1'b0, "R3 quarter boundary");
      req(16'h0BFF, 8'h00, 1'b0, "R4 below quarter");
      req(16'hFFFF, 8'h09, 1'b0, "R6 select half");
      req(16'h0800, 8'h00, 1'b0, "R3 half boundary");
      req(16'h07FF, 8'h00, 1'b0, "R4 below half");
      req(16'hFFFF, 8'h0D, 1'b0, "R6 select all");
      req(16'h0000, 8'h00, 1'b0, "R3 all protected");
      req(16'h1000, 8'h00, 1'b0, "R9 gap low");
      req(16'hFFFE, 8'h00, 1'b0, "R9 gap high");
      req(16'hFFFF, 8'h85, 1'b0, "R8 set hwen pin low");
      req(16'hFFFF, 8'h81, 1'b0, "R8 change blk pin low");
      req(16'hFFFF, 8'h8D, 1'b1, "R7 locked refuse");
      idle("R7 locked hold");
      req(16'hFFFF, 8'h00, 1'b1, "R7 locked clear latch");
      req(16'h0100, 8'h00, 1'b1, "R2 latch cleared");
      req(16'hFFFF, 8'h01, 1'b1, "R5 latch while locked");
      req(16'hFFFF, 8'h01, 1'b0, "R8 unlock clear hwen");
      idle("R10 quiet");
      idle("R11 hold");

      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a;
         int sel;
         sel = int'($urandom % 10);
         if (sel < 5)       a = AW'($urandom % N);
         else if (sel < 8)  a = '1;
         else               a = AW'(N + int'($urandom % (65535 - N)));
         req(a, DW'($urandom), 1'($urandom), "R10 random traffic");
         if ($urandom % 8 == 0) idle("R11 random idle");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule